// File: doc/BRIEF.md
# Framebuffer Burst Fetch Engine

This block reads a framebuffer out of memory for a display pipeline. It walks the visible part of a frame as a sequence of 32-bit words, issues fixed-maximum-length burst read requests on a simple request/response port, and writes each returned word into a pixel FIFO. The FIFO feeds the downstream pixel unpacker. When a visible line ends, the read address jumps forward by a programmable byte count, so a virtual screen wider than the visible area can be panned. A 5-bit starting bit offset is passed on to the unpacker. When the programmed number of frame words has been fetched, the address returns to the frame base.

Software sets the next configuration on a set of input fields. The engine copies those fields into its working copy only when an update strobe is pulsed, so a half-written configuration never reaches the fetch logic. Three interrupt sources are recorded in sticky status bits, and each source has its own mask bit. The sources are FIFO underflow, a discarded response word, and a memory error. An underflow stops the engine once its current burst has finished. The engine then waits for software to disable and re-enable it.

The controller has four states. `S_IDLE` holds the frame counters at the base, flushes the FIFO, and moves to `S_REQ` when the engine is enabled. `S_REQ` raises a request once the FIFO has room and moves to `S_BURST` when the request is accepted. From `S_REQ` it goes back to `S_IDLE` on disable, or to `S_HALT` if an underflow is pending. `S_BURST` collects the response words. On the last word it goes to `S_IDLE` if the engine is disabled, to `S_HALT` if an underflow is pending, and otherwise back to `S_REQ`. `S_HALT` stays put until the engine is disabled, then goes to `S_IDLE`.

Top module: `fbdma_fetch`

## Requirements
- R1: After reset there is no request, `busy` and `pix_valid` are low, `irq` is low, and `irq_status`, `irq_mask` and `pix_bit_ofs` are zero.
- R2: A request covers min(BURST, words left in the line, words left in the frame) words, and `rd_len_m1` carries that count minus one. A request is raised only while FIFO occupancy is at or below DEPTH − (2·BURST + 3).
- R3: Within a line, each word address is 4 bytes above the one before it. After the last word of a line, the next line starts `cfg_skip_bytes` bytes after the byte following that last word.
- R4: Once the active frame word count has been fetched, the next request starts again at the active base address.
- R5: `pix_sol` is high on the first word of every line and low on every other word. `pix_data` is the returned memory word.
- R6: Changes to `cfg_base`, `cfg_line_words`, `cfg_skip_bytes`, `cfg_frame_words` and `cfg_bit_ofs` have no effect until `upd` is pulsed. `pix_bit_ofs` shows the active bit offset.
- R7: A pop while the FIFO is empty and the engine is enabled is an underflow. It sets `irq_status` bit 0. A burst already accepted still completes, and no further request is made until `en` is dropped and raised again. After that, fetching resumes from the frame base.
- R8: When `en` is dropped during a burst, `busy` stays high until every word of that burst has arrived. The engine then goes idle with the FIFO emptied.
- R9: `irq_status` bit 1 is set by a response word that arrives while the FIFO is full or no burst is outstanding. Bit 2 is set by a response word with `rsp_err` high. All status bits are sticky and are cleared by writing one to the matching `irq_clr` bit.
- R10: `irq_en_set` sets mask bits and `irq_en_clr` clears them, with clear taking precedence when both are given. `irq` is high when any status bit has its mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Fetch enable |
| upd | input | 1 | Update strobe: copy the configuration fields into the active set |
| cfg_base | input | AW | Frame base byte address |
| cfg_line_words | input | LW_W | Visible words per line |
| cfg_skip_bytes | input | SK_W | Bytes skipped after each line |
| cfg_frame_words | input | FW_W | Visible words per frame |
| cfg_bit_ofs | input | 5 | Starting bit within the first word of a line |
| rd_req | output | 1 | Burst read request |
| rd_ready | input | 1 | Request accepted when high with `rd_req` |
| rd_addr | output | AW | Burst start byte address |
| rd_len_m1 | output | BLW | Burst word count minus one |
| rsp_valid | input | 1 | Response word valid |
| rsp_data | input | 32 | Response word |
| rsp_err | input | 1 | Memory error on this response word |
| pix_pop | input | 1 | Consumer pops the FIFO head |
| pix_valid | output | 1 | FIFO not empty |
| pix_data | output | 32 | FIFO head word |
| pix_sol | output | 1 | FIFO head is the first word of a line |
| pix_bit_ofs | output | 5 | Active starting bit offset |
| busy | output | 1 | Engine not idle |
| irq_en_set | input | 3 | Set mask bits |
| irq_en_clr | input | 3 | Clear mask bits |
| irq_clr | input | 3 | Clear status bits (write one) |
| irq_status | output | 3 | Sticky status: bit 0 underflow, bit 1 discarded word, bit 2 memory error |
| irq_mask | output | 3 | Mask bits |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets three kinds of boundary: where a line ends in the middle of a burst, where the frame wraps, and where the FIFO occupancy crosses the refill threshold. A design that split bursts wrongly would show the wrong request lengths. A design that dropped the skip or the wrap would return the wrong address for a word. A design that was off by one at the threshold would issue one request too many or too few. The bench also brings on an underflow while a delayed burst is still in flight. A design that stopped at once would leave the FIFO empty, and one that kept going would issue new requests. A delayed burst is likewise used to check that `busy` is held after disable, and that configuration written without the update strobe does not change the first address fetched.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_REQ   = 2'd1,
        S_BURST = 2'd2,
        S_HALT  = 2'd3
    } fetch_state_e;

    localparam int IRQ_N     = 3;
    localparam int IRQ_UFLOW = 0;
    localparam int IRQ_OVWR  = 1;
    localparam int IRQ_MERR  = 2;
endpackage

// File: rtl/fbdma_cfg_shadow.sv
module fbdma_cfg_shadow #(
    parameter int AW   = 32,
    parameter int LW_W = 12,
    parameter int FW_W = 20,
    parameter int SK_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd,
    input  logic [AW-1:0]   sw_base,
    input  logic [LW_W-1:0] sw_line_words,
    input  logic [SK_W-1:0] sw_skip_bytes,
    input  logic [FW_W-1:0] sw_frame_words,
    input  logic [4:0]      sw_bit_ofs,
    output logic [AW-1:0]   act_base,
    output logic [LW_W-1:0] act_line_words,
    output logic [SK_W-1:0] act_skip_bytes,
    output logic [FW_W-1:0] act_frame_words,
    output logic [4:0]      act_bit_ofs
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_base        <= '0;
            act_line_words  <= '0;
            act_skip_bytes  <= '0;
            act_frame_words <= '0;
            act_bit_ofs     <= '0;
        end else if (upd) begin
            act_base        <= sw_base;
            act_line_words  <= sw_line_words;
            act_skip_bytes  <= sw_skip_bytes;
            act_frame_words <= sw_frame_words;
            act_bit_ofs     <= sw_bit_ofs;
        end
    end

    // R6: the working copy moves only on the strobe
    a_r6_hold_base: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(act_base));
    a_r6_hold_ofs: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(act_bit_ofs));
endmodule

// File: rtl/fbdma_fifo.sv
module fbdma_fifo #(
    parameter int WIDTH = 33,
    parameter int DEPTH = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: occupancy never passes the storage size
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R8: a flush leaves the FIFO empty
    a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/fbdma_irq.sv
module fbdma_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] set_en,
    input  logic [N-1:0] clr_en,
    input  logic [N-1:0] clr,
    output logic [N-1:0] status,
    output logic [N-1:0] mask,
    output logic         irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= (status & ~clr) | ev;
            mask   <= (mask | set_en) & ~clr_en;
        end
    end

    assign irq = |(status & mask);

    // R9: a cleared bit with no new event reads back zero
    a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr != '0) && ((clr & ev) == '0)) |=> ((status & $past(clr)) == '0));
    // R10: no mask bit, no interrupt
    a_r10_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
endmodule

// File: rtl/fbdma_fetch.sv
module fbdma_fetch
    import fbdma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LW_W  = 12,
    parameter int FW_W  = 20,
    parameter int SK_W  = 16,
    parameter int DEPTH = 512,
    parameter int BURST = 8,
    parameter int BLW   = (BURST > 1) ? $clog2(BURST) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            upd,
    input  logic [AW-1:0]   cfg_base,
    input  logic [LW_W-1:0] cfg_line_words,
    input  logic [SK_W-1:0] cfg_skip_bytes,
    input  logic [FW_W-1:0] cfg_frame_words,
    input  logic [4:0]      cfg_bit_ofs,
    output logic            rd_req,
    input  logic            rd_ready,
    output logic [AW-1:0]   rd_addr,
    output logic [BLW-1:0]  rd_len_m1,
    input  logic            rsp_valid,
    input  logic [31:0]     rsp_data,
    input  logic            rsp_err,
    input  logic            pix_pop,
    output logic            pix_valid,
    output logic [31:0]     pix_data,
    output logic            pix_sol,
    output logic [4:0]      pix_bit_ofs,
    output logic            busy,
    input  logic [IRQ_N-1:0] irq_en_set,
    input  logic [IRQ_N-1:0] irq_en_clr,
    input  logic [IRQ_N-1:0] irq_clr,
    output logic [IRQ_N-1:0] irq_status,
    output logic [IRQ_N-1:0] irq_mask,
    output logic            irq
);
    localparam int CW     = $clog2(DEPTH+1);
    localparam int THRESH = DEPTH - (2*BURST + 3);
    localparam int LN_W   = BLW + 1;

    // active configuration
    logic [AW-1:0]   a_base;
    logic [LW_W-1:0] a_line;
    logic [SK_W-1:0] a_skip;
    logic [FW_W-1:0] a_frame;
    logic [4:0]      a_ofs;

    fbdma_cfg_shadow #(.AW(AW), .LW_W(LW_W), .FW_W(FW_W), .SK_W(SK_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .upd(upd),
        .sw_base(cfg_base), .sw_line_words(cfg_line_words),
        .sw_skip_bytes(cfg_skip_bytes), .sw_frame_words(cfg_frame_words),
        .sw_bit_ofs(cfg_bit_ofs),
        .act_base(a_base), .act_line_words(a_line), .act_skip_bytes(a_skip),
        .act_frame_words(a_frame), .act_bit_ofs(a_ofs)
    );

    fetch_state_e state, nstate;

    logic [AW-1:0]   addr_q;
    logic [LW_W-1:0] line_left_q;
    logic [FW_W-1:0] frame_left_q;
    logic [LN_W-1:0] blen_q, rcv_q;
    logic            bsol_q, uflow_pend;

    // FIFO side
    logic            f_push, f_empty, f_full, f_flush;
    logic [32:0]     f_dout;
    logic [CW-1:0]   f_cnt;

    // burst sizing
    logic [FW_W-1:0] line_ext, len_a, len_w;
    logic [LN_W-1:0] cur_len, cur_len_m1;
    logic            room, accept, line_end, frame_end;
    logic            in_burst, take, last_word;
    logic            uflow_ev, ovwr_ev, merr_ev;

    assign line_ext   = FW_W'(line_left_q);
    assign len_a      = (line_ext < frame_left_q) ? line_ext : frame_left_q;
    assign len_w      = (len_a < FW_W'(BURST)) ? len_a : FW_W'(BURST);
    assign cur_len    = len_w[LN_W-1:0];
    assign cur_len_m1 = cur_len - 1'b1;
    assign line_end   = (len_w == line_ext);
    assign frame_end  = (len_w == frame_left_q);

    assign room      = (f_cnt <= CW'(THRESH));
    assign rd_req    = (state == S_REQ) && en && !uflow_pend && room;
    assign accept    = rd_req && rd_ready;
    assign rd_addr   = addr_q;
    assign rd_len_m1 = cur_len_m1[BLW-1:0];

    assign in_burst  = (state == S_BURST);
    assign take      = rsp_valid && in_burst;
    assign last_word = take && ((rcv_q + 1'b1) == blen_q);
    assign f_push    = take && !f_full;
    assign f_flush   = (state == S_IDLE);

    assign uflow_ev  = pix_pop && f_empty && en && (state != S_IDLE);
    assign ovwr_ev   = rsp_valid && (!in_burst || f_full);
    assign merr_ev   = take && rsp_err;

    fbdma_fifo #(.WIDTH(33), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(f_flush),
        .push(f_push), .din({bsol_q && (rcv_q == '0), rsp_data}),
        .pop(pix_pop), .dout(f_dout),
        .empty(f_empty), .full(f_full), .count(f_cnt)
    );

    logic [IRQ_N-1:0] ev_vec;
    always_comb begin
        ev_vec            = '0;
        ev_vec[IRQ_UFLOW] = uflow_ev;
        ev_vec[IRQ_OVWR]  = ovwr_ev;
        ev_vec[IRQ_MERR]  = merr_ev;
    end

    fbdma_irq #(.N(IRQ_N)) u_irq (
        .clk(clk), .rst_n(rst_n), .ev(ev_vec),
        .set_en(irq_en_set), .clr_en(irq_en_clr), .clr(irq_clr),
        .status(irq_status), .mask(irq_mask), .irq(irq)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:  if (en) nstate = S_REQ;
            S_REQ: begin
                if (!en)             nstate = S_IDLE;
                else if (uflow_pend) nstate = S_HALT;
                else if (accept)     nstate = S_BURST;
            end
            S_BURST: begin
                if (last_word) begin
                    if (!en)                         nstate = S_IDLE;
                    else if (uflow_pend || uflow_ev) nstate = S_HALT;
                    else                             nstate = S_REQ;
                end
            end
            S_HALT:  if (!en) nstate = S_IDLE;
            default: nstate = S_IDLE;
        endcase
    end

    // datapath: address walk, burst tracking, underflow latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q       <= '0;
            line_left_q  <= '0;
            frame_left_q <= '0;
            blen_q       <= '0;
            rcv_q        <= '0;
            bsol_q       <= 1'b0;
            uflow_pend   <= 1'b0;
        end else begin
            if (state == S_IDLE) begin
                addr_q       <= a_base;
                line_left_q  <= a_line;
                frame_left_q <= a_frame;
            end else if (accept) begin
                blen_q <= cur_len;
                rcv_q  <= '0;
                bsol_q <= (line_left_q == a_line);
                if (frame_end) begin
                    addr_q       <= a_base;
                    line_left_q  <= a_line;
                    frame_left_q <= a_frame;
                end else if (line_end) begin
                    addr_q       <= addr_q + (AW'(cur_len) << 2) + AW'(a_skip);
                    line_left_q  <= a_line;
                    frame_left_q <= frame_left_q - FW_W'(cur_len);
                end else begin
                    addr_q       <= addr_q + (AW'(cur_len) << 2);
                    line_left_q  <= line_left_q - LW_W'(cur_len);
                    frame_left_q <= frame_left_q - FW_W'(cur_len);
                end
            end
            if (take) rcv_q <= rcv_q + 1'b1;
            if (state == S_IDLE) uflow_pend <= 1'b0;
            else if (uflow_ev)   uflow_pend <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        pix_valid   = !f_empty;
        pix_data    = f_dout[31:0];
        pix_sol     = f_dout[32];
        pix_bit_ofs = a_ofs;
        busy        = (state != S_IDLE);
    end

    // R7: an underflow blocks the next request
    a_r7_no_req_after_uflow: assert property (@(posedge clk) disable iff (!rst_n)
        uflow_ev |=> !rd_req);
    // R8: the engine only goes idle after a disable
    a_r8_idle_needs_disable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(en));
    // R2: a request never asks for more than one burst
    a_r2_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (cur_len != '0) && (cur_len <= LN_W'(BURST)));
endmodule

// File: tb/fbdma_fetch_tb.sv
`timescale 1ns/1ps
module fbdma_fetch_tb;
    localparam int DEPTH = 16;
    localparam int BURST = 4;
    localparam int BLW   = 2;
    localparam logic [31:0] BASE_A = 32'h1000;
    localparam logic [31:0] BASE_B = 32'h2000;
    localparam int LINE  = 6;
    localparam int FRAME = 12;
    localparam int SKIP  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, upd = 1'b0;
    logic [31:0] cfg_base = BASE_A;
    logic [11:0] cfg_line_words = 12'(LINE);
    logic [15:0] cfg_skip_bytes = 16'(SKIP);
    logic [19:0] cfg_frame_words = 20'(FRAME);
    logic [4:0]  cfg_bit_ofs = 5'd3;
    logic rd_req, rd_ready;
    logic [31:0] rd_addr;
    logic [BLW-1:0] rd_len_m1;
    logic rsp_valid, rsp_valid_m = 1'b0, stray = 1'b0;
    logic [31:0] rsp_data = '0;
    logic rsp_err = 1'b0;
    logic pix_pop = 1'b0, pix_valid, pix_sol;
    logic [31:0] pix_data;
    logic [4:0] pix_bit_ofs;
    logic busy, irq;
    logic [2:0] irq_en_set = '0, irq_en_clr = '0, irq_clr = '0, irq_status, irq_mask;

    logic mem_on = 1'b1;
    int   mem_delay = 0;
    logic err_inject = 1'b0;
    int   req_n = 0;
    logic [31:0] log_addr [256];
    int   log_len [256];
    int   total = 0, bad = 0;

    assign rd_ready  = mem_on;
    assign rsp_valid = rsp_valid_m | stray;

    always #2 clk = ~clk;

    fbdma_fetch #(.DEPTH(DEPTH), .BURST(BURST)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .upd(upd),
        .cfg_base(cfg_base), .cfg_line_words(cfg_line_words),
        .cfg_skip_bytes(cfg_skip_bytes), .cfg_frame_words(cfg_frame_words),
        .cfg_bit_ofs(cfg_bit_ofs),
        .rd_req(rd_req), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_len_m1(rd_len_m1),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .pix_pop(pix_pop), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_sol(pix_sol), .pix_bit_ofs(pix_bit_ofs), .busy(busy),
        .irq_en_set(irq_en_set), .irq_en_clr(irq_en_clr), .irq_clr(irq_clr),
        .irq_status(irq_status), .irq_mask(irq_mask), .irq(irq)
    );

    // memory model: sees requests at the falling edge, answers with addressed words
    initial begin
        forever begin
            @(negedge clk);
            rsp_valid_m = 1'b0;
            rsp_err = 1'b0;
            if (rd_req && rd_ready) begin
                logic [31:0] a;
                int n;
                a = rd_addr;
                n = int'(rd_len_m1) + 1;
                if (req_n < 256) begin
                    log_addr[req_n] = a;
                    log_len[req_n]  = n;
                end
                req_n++;
                repeat (mem_delay) @(negedge clk);
                for (int i = 0; i < n; i++) begin
                    @(negedge clk);
                    rsp_valid_m = 1'b1;
                    rsp_data    = a + 32'(4*i);
                    rsp_err     = err_inject;
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [31:0] base, input int k);
        int w, ln, col;
        w   = k % FRAME;
        ln  = w / LINE;
        col = w % LINE;
        return base + 32'(ln * (LINE*4 + SKIP)) + 32'(col * 4);
    endfunction

    task automatic pop_expect(input string req, input logic [31:0] exp, input logic exp_sol);
        int guard = 0;
        while (!pix_valid && guard < 200) begin
            tick(1);
            guard++;
        end
        check(req, pix_data, exp);
        check(req, 32'(pix_sol), 32'(exp_sol));
        pix_pop = 1'b1;
        tick(1);
        pix_pop = 1'b0;
    endtask

    task automatic go_idle(input string req);
        int guard = 0;
        en = 1'b0;
        while (busy && guard < 300) begin
            tick(1);
            guard++;
        end
        tick(2);
        check(req, 32'(busy), 32'd0);
        check(req, 32'(pix_valid), 32'd0);
    endtask

    task automatic pulse_upd();
        upd = 1'b1;
        tick(1);
        upd = 1'b0;
        tick(1);
    endtask

    task automatic t_reset();
        // R1
        check("R1 busy", 32'(busy), 0);
        check("R1 rd_req", 32'(rd_req), 0);
        check("R1 pix_valid", 32'(pix_valid), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 status", 32'(irq_status), 0);
        check("R1 mask", 32'(irq_mask), 0);
        check("R1 bit_ofs", 32'(pix_bit_ofs), 0);
        pulse_upd();
        check("R6 bit_ofs after upd", 32'(pix_bit_ofs), 3);
    endtask

    task automatic t_stream();
        int r0;
        r0 = req_n;
        en = 1'b1;
        tick(60);
        // R2: 0 -> 4 words, 4 <= 5 -> 2 more words, 6 > 5 -> stop
        check("R2 request count at threshold", 32'(req_n - r0), 2);
        check("R2 first addr", log_addr[r0], BASE_A);
        check("R2 first len", 32'(log_len[r0]), 4);
        check("R2 line tail addr", log_addr[r0+1], BASE_A + 32'h10);
        check("R2 line tail len", 32'(log_len[r0+1]), 2);
        pop_expect("R5 first word", exp_addr(BASE_A, 0), 1'b1);
        tick(30);
        check("R2 refill after one pop", 32'(req_n - r0), 3);
        check("R3 second line addr after skip", log_addr[r0+2], BASE_A + 32'h20);
        check("R2 refill len", 32'(log_len[r0+2]), 4);
        for (int k = 1; k < 30; k++)
            pop_expect("R3/R4/R5 stream", exp_addr(BASE_A, k), (k % LINE) == 0);
        check("R4 wrap request addr", log_addr[r0+4], BASE_A);
        check("R2 second line tail len", 32'(log_len[r0+3]), 2);
        go_idle("R8 idle after stream");
    endtask

    task automatic t_shadow();
        cfg_base = BASE_B;
        cfg_bit_ofs = 5'd9;
        tick(3);
        check("R6 offset unchanged without upd", 32'(pix_bit_ofs), 3);
        en = 1'b1;
        pop_expect("R6 base unchanged without upd", BASE_A, 1'b1);
        go_idle("R6 idle");
        pulse_upd();
        check("R6 offset after upd", 32'(pix_bit_ofs), 9);
        en = 1'b1;
        pop_expect("R6 new base after upd", BASE_B, 1'b1);
        go_idle("R6 idle 2");
        cfg_base = BASE_A;
        cfg_bit_ofs = 5'd3;
        pulse_upd();
    endtask

    task automatic t_underflow();
        int rn;
        en = 1'b1;
        tick(40);
        mem_delay = 20;
        for (int k = 0; k < 6; k++)
            pop_expect("R7 drain", exp_addr(BASE_A, k), (k % LINE) == 0);
        check("R7 fifo empty before underflow", 32'(pix_valid), 0);
        pix_pop = 1'b1;
        tick(1);
        pix_pop = 1'b0;
        rn = req_n;
        check("R7 underflow status", 32'(irq_status[0]), 1);
        tick(80);
        check("R7 no new request after underflow", 32'(req_n), 32'(rn));
        check("R7 pending burst completed", 32'(pix_valid), 1);
        check("R7 still busy while halted", 32'(busy), 1);
        mem_delay = 0;
        go_idle("R7 disable clears halt");
        en = 1'b1;
        pop_expect("R7 restart at base", BASE_A, 1'b1);
        go_idle("R7 idle");
        irq_clr = 3'b001;
        tick(1);
        irq_clr = 3'b000;
        tick(1);
        check("R9 underflow cleared", 32'(irq_status[0]), 0);
    endtask

    task automatic t_drain();
        mem_delay = 20;
        en = 1'b1;
        tick(4);
        en = 1'b0;
        tick(10);
        check("R8 busy held during burst", 32'(busy), 1);
        tick(40);
        check("R8 idle after burst", 32'(busy), 0);
        check("R8 fifo flushed", 32'(pix_valid), 0);
        mem_delay = 0;
    endtask

    task automatic t_irq();
        stray = 1'b1;
        tick(1);
        stray = 1'b0;
        tick(1);
        check("R9 discarded word status", 32'(irq_status[1]), 1);
        err_inject = 1'b1;
        en = 1'b1;
        tick(20);
        go_idle("R9 idle");
        err_inject = 1'b0;
        check("R9 memory error status", 32'(irq_status[2]), 1);
        check("R10 irq low without mask", 32'(irq), 0);
        irq_en_set = 3'b100;
        tick(1);
        irq_en_set = 3'b000;
        tick(1);
        check("R10 mask readback", 32'(irq_mask), 4);
        check("R10 irq with mask", 32'(irq), 1);
        irq_en_set = 3'b010;
        irq_en_clr = 3'b010;
        tick(1);
        irq_en_set = 3'b000;
        irq_en_clr = 3'b000;
        tick(1);
        check("R10 clear wins", 32'(irq_mask), 4);
        irq_en_clr = 3'b100;
        tick(1);
        irq_en_clr = 3'b000;
        tick(1);
        check("R10 irq after unmask", 32'(irq), 0);
        irq_en_set = 3'b010;
        tick(1);
        irq_en_set = 3'b000;
        tick(1);
        check("R10 irq on bit1", 32'(irq), 1);
        irq_clr = 3'b110;
        tick(1);
        irq_clr = 3'b000;
        tick(1);
        check("R9 status cleared", 32'(irq_status), 0);
        check("R9 irq after clear", 32'(irq), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_stream();
        t_shadow();
        t_underflow();
        t_drain();
        t_irq();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule